// File: doc/BRIEF.md
# Request Bus Packet Deserializer

This block sits behind the receive-clock sampling point of a packetized DRAM device. Each clock it samples an 8-bit request bus. The three upper lanes carry row traffic and the five lower lanes carry column traffic. A framing input marks the first sample of each packet window, and a window lasts eight samples. Over one window the row lanes build a 24-bit row packet. The column lanes build a 40-bit stream, which is cut into a 23-bit column-operation packet and a 17-bit auxiliary packet.

When a window completes, all three packets appear together with one-cycle valid strobes. Two type tags come with them. The row tag tells an activate packet from a row-operation packet. The auxiliary tag tells a mask packet from an extended-operation packet. The block does not interpret any of the command fields.

Control is a two-state machine:
- `ST_HUNT` waits for a framing mark. Samples seen in this state are dropped.
- `ST_FILL` collects the remaining samples of the window.

The transitions are:
- HUNT→FILL when a framing mark arrives.
- FILL→FILL when a new mark restarts the window.
- FILL→FILL while the sample count has not yet reached the last slot.
- FILL→HUNT on the last sample of the window. This transition issues the packets.

Top module: `rqd_top`

## Requirements
- R1: During synchronous reset and on the first cycle after it, all valid strobes are 0. All packet and tag outputs are 0 until the first packet is issued. A window that reset interrupts produces no packet.
- R2: Samples are numbered 0 to 7 from the framing mark. The row packet is the concatenation of lanes [7:5] of those samples, with sample 0 in bits [23:21] and sample 7 in bits [2:0].
- R3: The row tag `row_is_act_o` equals row packet bit 23, which is lane 7 of sample 0. A value of 1 means activate and 0 means row operation.
- R4: The column stream is the concatenation of lanes [4:0] of samples 0 to 7, with sample 0 most significant (stream bit 39). The column-operation packet is stream bits [39:17], which are the first 23 bits to arrive.
- R5: The auxiliary packet is stream bits [16:0], the last 17 bits to arrive. Its tag `aux_is_ext_o` equals auxiliary bit 16, which is lane 1 of sample 4. A value of 1 means extended operation and 0 means mask.
- R6: The three valid strobes rise together in the cycle after the clock edge that samples the eighth sample. They last exactly one cycle.
- R7: Samples taken without a preceding framing mark (state `ST_HUNT`) are ignored and produce no packet.
- R8: A framing mark during a window, including on its eighth slot, discards the partial window and starts a new one at sample 0.
- R9: Windows may be back to back, with a mark on the sample straight after a completed window. Each completed window then yields its own packet. After a completion, a new mark is required.
- R10: Packet and tag outputs hold their last issued values while no valid strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; request lanes are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame_i | input | 1 | Marks the first sample of a packet window |
| rq_i | input | 8 | Request bus; [7:5] row lanes, [4:0] column lanes |
| row_pkt_o | output | 24 | Assembled row packet |
| row_vld_o | output | 1 | One-cycle strobe for a new row packet |
| row_is_act_o | output | 1 | Row packet kind: 1 activate, 0 row operation |
| colop_pkt_o | output | 23 | Assembled column-operation packet |
| colop_vld_o | output | 1 | One-cycle strobe for a new column-operation packet |
| aux_pkt_o | output | 17 | Assembled mask or extended-operation packet |
| aux_vld_o | output | 1 | One-cycle strobe for a new auxiliary packet |
| aux_is_ext_o | output | 1 | Auxiliary packet kind: 1 extended operation, 0 mask |

## Verification
The hardest case to reach from the ports is a framing mark that lands inside an open window, most of all on its eighth slot. At that point the machine is one sample away from issuing a packet. To reach it, the bench drives a deliberately truncated window and then a complete one, or a seven-sample window whose next sample carries a new mark. It then checks that exactly one packet appears and that it carries the second window's contents. A reset that arrives in the middle of a window is reached the same way, by stopping the sample sequence partway through.

// File: rtl/rqd_pkg.sv
package rqd_pkg;
    localparam int ROW_LANES    = 3;
    localparam int COL_LANES    = 5;
    localparam int WIN_LEN      = 8;
    localparam int COLOP_W      = 23;
    localparam int RQ_W         = ROW_LANES + COL_LANES;
    localparam int ROW_PKT_W    = ROW_LANES * WIN_LEN;
    localparam int COL_STREAM_W = COL_LANES * WIN_LEN;
    localparam int AUX_W        = COL_STREAM_W - COLOP_W;

    typedef enum logic [0:0] {
        ST_HUNT = 1'b0,
        ST_FILL = 1'b1
    } frm_state_t;
endpackage

// File: rtl/rqd_framer.sv
module rqd_framer
    import rqd_pkg::*;
#(
    parameter int WIN = WIN_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_i,
    output logic shift_o,
    output logic done_o
);
    localparam int CNT_W = (WIN > 2) ? $clog2(WIN) : 1;
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(WIN - 1);
    localparam logic [CNT_W-1:0] FIRST_NEXT = CNT_W'(1);

    frm_state_t       state_q;
    frm_state_t       state_d;
    logic [CNT_W-1:0] slot_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (frame_i) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (frame_i)                 state_d = ST_FILL;
                else if (slot_q == LAST_SLOT) state_d = ST_HUNT;
                else                          state_d = ST_FILL;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HUNT;
        else     state_q <= state_d;
    end

    // slot index of the sample expected on the next edge
    always_ff @(posedge clk) begin
        if (rst)                    slot_q <= '0;
        else if (frame_i)           slot_q <= FIRST_NEXT;
        else if (state_q == ST_FILL) slot_q <= slot_q + FIRST_NEXT;
    end

    // outputs of the machine
    always_comb begin
        shift_o = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                shift_o = frame_i;
            end
            ST_FILL: begin
                shift_o = 1'b1;
                done_o  = !frame_i && (slot_q == LAST_SLOT);
            end
            default: begin
                shift_o = 1'b0;
                done_o  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rqd_lane_shift.sv
module rqd_lane_shift #(
    parameter int LANES = 3,
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   shift_i,
    input  logic [LANES-1:0]       lanes_i,
    output logic [LANES*DEPTH-1:0] word_o
);
    localparam int HIST_W = LANES * (DEPTH - 1);

    logic [HIST_W-1:0] hist_q;

    generate
        if (DEPTH > 2) begin : g_deep
            always_ff @(posedge clk) begin
                if (rst)          hist_q <= '0;
                else if (shift_i) hist_q <= {hist_q[HIST_W-LANES-1:0], lanes_i};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst)          hist_q <= '0;
                else if (shift_i) hist_q <= lanes_i;
            end
        end
    endgenerate

    // earlier samples sit above the one being taken now
    assign word_o = {hist_q, lanes_i};
endmodule

// File: rtl/rqd_pkt_reg.sv
module rqd_pkt_reg
    import rqd_pkg::*;
#(
    parameter int ROW_W   = ROW_PKT_W,
    parameter int COL_W   = COL_STREAM_W,
    parameter int OP_W    = COLOP_W,
    parameter int ROW_TAG = ROW_PKT_W - 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 done_i,
    input  logic [ROW_W-1:0]     row_word_i,
    input  logic [COL_W-1:0]     col_word_i,
    output logic [ROW_W-1:0]     row_pkt_o,
    output logic                 row_vld_o,
    output logic                 row_is_act_o,
    output logic [OP_W-1:0]      colop_pkt_o,
    output logic                 colop_vld_o,
    output logic [COL_W-OP_W-1:0] aux_pkt_o,
    output logic                 aux_vld_o,
    output logic                 aux_is_ext_o
);
    localparam int AW = COL_W - OP_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_pkt_o    <= '0;
            row_is_act_o <= 1'b0;
            colop_pkt_o  <= '0;
            aux_pkt_o    <= '0;
            aux_is_ext_o <= 1'b0;
        end else if (done_i) begin
            row_pkt_o    <= row_word_i;
            row_is_act_o <= row_word_i[ROW_TAG];
            colop_pkt_o  <= col_word_i[COL_W-1:AW];
            aux_pkt_o    <= col_word_i[AW-1:0];
            aux_is_ext_o <= col_word_i[AW-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_vld_o   <= 1'b0;
            colop_vld_o <= 1'b0;
            aux_vld_o   <= 1'b0;
        end else begin
            row_vld_o   <= done_i;
            colop_vld_o <= done_i;
            aux_vld_o   <= done_i;
        end
    end
endmodule

// File: rtl/rqd_top.sv
module rqd_top
    import rqd_pkg::*;
#(
    parameter int ROW_N = ROW_LANES,
    parameter int COL_N = COL_LANES,
    parameter int WIN   = WIN_LEN,
    parameter int OP_W  = COLOP_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_i,
    input  logic [ROW_N+COL_N-1:0]   rq_i,
    output logic [ROW_N*WIN-1:0]     row_pkt_o,
    output logic                     row_vld_o,
    output logic                     row_is_act_o,
    output logic [OP_W-1:0]          colop_pkt_o,
    output logic                     colop_vld_o,
    output logic [COL_N*WIN-OP_W-1:0] aux_pkt_o,
    output logic                     aux_vld_o,
    output logic                     aux_is_ext_o
);
    localparam int RQ_BITS = ROW_N + COL_N;
    localparam int RW      = ROW_N * WIN;
    localparam int CW      = COL_N * WIN;

    logic          shift;
    logic          done;
    logic [RW-1:0] row_word;
    logic [CW-1:0] col_word;

    rqd_framer #(.WIN(WIN)) u_framer (
        .clk     (clk),
        .rst     (rst),
        .frame_i (frame_i),
        .shift_o (shift),
        .done_o  (done)
    );

    rqd_lane_shift #(.LANES(ROW_N), .DEPTH(WIN)) u_row_shift (
        .clk     (clk),
        .rst     (rst),
        .shift_i (shift),
        .lanes_i (rq_i[RQ_BITS-1:COL_N]),
        .word_o  (row_word)
    );

    rqd_lane_shift #(.LANES(COL_N), .DEPTH(WIN)) u_col_shift (
        .clk     (clk),
        .rst     (rst),
        .shift_i (shift),
        .lanes_i (rq_i[COL_N-1:0]),
        .word_o  (col_word)
    );

    rqd_pkt_reg #(
        .ROW_W   (RW),
        .COL_W   (CW),
        .OP_W    (OP_W),
        .ROW_TAG (RW - 1)
    ) u_out (
        .clk          (clk),
        .rst          (rst),
        .done_i       (done),
        .row_word_i   (row_word),
        .col_word_i   (col_word),
        .row_pkt_o    (row_pkt_o),
        .row_vld_o    (row_vld_o),
        .row_is_act_o (row_is_act_o),
        .colop_pkt_o  (colop_pkt_o),
        .colop_vld_o  (colop_vld_o),
        .aux_pkt_o    (aux_pkt_o),
        .aux_vld_o    (aux_vld_o),
        .aux_is_ext_o (aux_is_ext_o)
    );
endmodule

// File: rtl/rqd_checker.sv
module rqd_checker #(
    parameter int RW   = 24,
    parameter int OPW  = 23,
    parameter int AW   = 17,
    parameter int WIN  = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          frame_i,
    input logic [RW-1:0] row_pkt_o,
    input logic          row_vld_o,
    input logic          row_is_act_o,
    input logic [OPW-1:0] colop_pkt_o,
    input logic          colop_vld_o,
    input logic [AW-1:0] aux_pkt_o,
    input logic          aux_vld_o,
    input logic          aux_is_ext_o
);
    localparam int SW = $clog2(WIN) + 2;
    localparam logic [SW-1:0] SAT = {SW{1'b1}};

    // cycles since the latest framing mark, saturating
    logic [SW-1:0] since_mark;
    logic          past_rst;

    always_ff @(posedge clk) begin
        past_rst <= rst;
        if (rst)                since_mark <= '0;
        else if (frame_i)       since_mark <= SW'(1);
        else if (since_mark != '0 && since_mark != SAT)
                                since_mark <= since_mark + SW'(1);
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        past_rst |-> !row_vld_o && !colop_vld_o && !aux_vld_o);

    assert_row_tag_R3: assert property (@(posedge clk) disable iff (rst)
        row_vld_o |-> row_is_act_o == row_pkt_o[RW-1]);

    assert_aux_tag_R5: assert property (@(posedge clk) disable iff (rst)
        aux_vld_o |-> aux_is_ext_o == aux_pkt_o[AW-1]);

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        row_vld_o |=> !row_vld_o);

    assert_strobes_together_R6: assert property (@(posedge clk) disable iff (rst)
        $countones({row_vld_o, colop_vld_o, aux_vld_o}) != 1
        && $countones({row_vld_o, colop_vld_o, aux_vld_o}) != 2);

    assert_window_from_mark_R8: assert property (@(posedge clk) disable iff (rst)
        row_vld_o |-> since_mark == SW'(WIN));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst || past_rst)
        !row_vld_o |-> $stable(row_pkt_o) && $stable(colop_pkt_o) && $stable(aux_pkt_o));
endmodule

bind rqd_top rqd_checker #(
    .RW  (ROW_N * WIN),
    .OPW (OP_W),
    .AW  (COL_N * WIN - OP_W),
    .WIN (WIN)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_i      (frame_i),
    .row_pkt_o    (row_pkt_o),
    .row_vld_o    (row_vld_o),
    .row_is_act_o (row_is_act_o),
    .colop_pkt_o  (colop_pkt_o),
    .colop_vld_o  (colop_vld_o),
    .aux_pkt_o    (aux_pkt_o),
    .aux_vld_o    (aux_vld_o),
    .aux_is_ext_o (aux_is_ext_o)
);

// File: tb/tb_rqd_top.sv
`timescale 1ns/1ps
module tb_rqd_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_i = 1'b0;
    logic [7:0]  rq_i = '0;
    logic [23:0] row_pkt_o;
    logic        row_vld_o, row_is_act_o;
    logic [22:0] colop_pkt_o;
    logic        colop_vld_o;
    logic [16:0] aux_pkt_o;
    logic        aux_vld_o, aux_is_ext_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rqd_top dut (
        .clk(clk), .rst(rst), .frame_i(frame_i), .rq_i(rq_i),
        .row_pkt_o(row_pkt_o), .row_vld_o(row_vld_o), .row_is_act_o(row_is_act_o),
        .colop_pkt_o(colop_pkt_o), .colop_vld_o(colop_vld_o),
        .aux_pkt_o(aux_pkt_o), .aux_vld_o(aux_vld_o), .aux_is_ext_o(aux_is_ext_o)
    );

    localparam int NV = 6;
    localparam logic [63:0] VEC [NV] = '{
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h0123_4567_89AB_CDEF,
        64'h8000_0000_0000_0000,
        64'h0000_0000_0200_0000,
        64'hA5A5_5A5A_C3C3_3C3C,
        64'h1F1F_1F1F_E0E0_E0E0
    };

    // monitor of issued packets
    int          n_pkt = 0;
    int          n_split = 0;
    logic [23:0] cap_row [4];
    logic [22:0] cap_op  [4];
    logic [16:0] cap_aux [4];
    logic        cap_act [4];
    logic        cap_ext [4];

    always @(negedge clk) begin
        if (row_vld_o != colop_vld_o || row_vld_o != aux_vld_o) n_split++;
        if (row_vld_o) begin
            cap_row[n_pkt % 4] = row_pkt_o;
            cap_op[n_pkt % 4]  = colop_pkt_o;
            cap_aux[n_pkt % 4] = aux_pkt_o;
            cap_act[n_pkt % 4] = row_is_act_o;
            cap_ext[n_pkt % 4] = aux_is_ext_o;
            n_pkt++;
        end
    end

    function automatic logic [23:0] exp_row(input logic [63:0] w);
        logic [23:0] r = '0;
        for (int k = 0; k < 8; k++) r = {r[20:0], w[63-8*k -: 3]};
        return r;
    endfunction

    function automatic logic [39:0] exp_col(input logic [63:0] w);
        logic [39:0] c = '0;
        for (int k = 0; k < 8; k++) c = {c[34:0], w[60-8*k -: 5]};
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drives n samples of window w, mark on the first when with_mark
    task automatic send(input logic [63:0] w, input int n, input bit with_mark);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            frame_i = with_mark && (k == 0);
            rq_i    = w[63-8*k -: 8];
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            frame_i = 1'b0;
            rq_i    = 8'h5A;
        end
    endtask

    task automatic check_pkt(input int idx, input logic [63:0] w, input string tag);
        logic [39:0] c;
        c = exp_col(w);
        check(cap_row[idx % 4] == exp_row(w), {tag, " R2 row"}, 64'(cap_row[idx % 4]), 64'(exp_row(w)));
        check(cap_act[idx % 4] == exp_row(w)[23], {tag, " R3 row tag"}, 64'(cap_act[idx % 4]), 64'(exp_row(w)[23]));
        check(cap_op[idx % 4] == c[39:17], {tag, " R4 colop"}, 64'(cap_op[idx % 4]), 64'(c[39:17]));
        check(cap_aux[idx % 4] == c[16:0], {tag, " R5 aux"}, 64'(cap_aux[idx % 4]), 64'(c[16:0]));
        check(cap_ext[idx % 4] == c[16], {tag, " R5 aux tag"}, 64'(cap_ext[idx % 4]), 64'(c[16]));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        logic [23:0] held_row;
        logic [22:0] held_op;
        logic [16:0] held_aux;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(row_vld_o == 0 && colop_vld_o == 0 && aux_vld_o == 0, "R1 valids in reset",
              64'({row_vld_o, colop_vld_o, aux_vld_o}), 64'h0);
        check(row_pkt_o == 0 && colop_pkt_o == 0 && aux_pkt_o == 0 && !row_is_act_o && !aux_is_ext_o,
              "R1 outputs in reset", 64'(row_pkt_o), 64'h0);
        rst = 1'b0;
        idle(2);
        check(n_pkt == 0, "R1 no packet after reset", 64'(n_pkt), 64'h0);

        // table walk: R2..R6
        for (int v = 0; v < NV; v++) begin
            base = n_pkt;
            send(VEC[v], 8, 1'b1);
            @(negedge clk);
            frame_i = 1'b0;
            check(row_vld_o && colop_vld_o && aux_vld_o, "R6 strobes after eighth sample",
                  64'({row_vld_o, colop_vld_o, aux_vld_o}), 64'h7);
            idle(3);
            check(n_pkt == base + 1, "R6 single pulse", 64'(n_pkt - base), 64'h1);
            check_pkt(base, VEC[v], "table");
        end

        // R10: outputs hold while quiet, lanes toggling without a mark
        held_row = row_pkt_o; held_op = colop_pkt_o; held_aux = aux_pkt_o;
        send(64'hDEAD_BEEF_0BAD_F00D, 8, 1'b0);
        idle(2);
        check(row_pkt_o == held_row && colop_pkt_o == held_op && aux_pkt_o == held_aux,
              "R10 hold", 64'(row_pkt_o), 64'(held_row));
        // R7: the unmarked window above produced nothing
        check(n_pkt == NV, "R7 unmarked samples ignored", 64'(n_pkt), 64'(NV));

        // R8: truncated window then full window
        base = n_pkt;
        send(64'hFFFF_FFFF_FF00_0000, 5, 1'b1);
        send(VEC[1], 8, 1'b1);
        idle(3);
        check(n_pkt == base + 1, "R8 restart count", 64'(n_pkt - base), 64'h1);
        check_pkt(base, VEC[1], "R8 restart");

        // R8: mark on the eighth slot
        base = n_pkt;
        send(64'hFFFF_FFFF_FFFF_FFFF, 7, 1'b1);
        send(VEC[4], 8, 1'b1);
        idle(3);
        check(n_pkt == base + 1, "R8 mark on last slot", 64'(n_pkt - base), 64'h1);
        check_pkt(base, VEC[4], "R8 last slot");

        // R9: back to back, then a mark is needed again
        base = n_pkt;
        send(VEC[2], 8, 1'b1);
        send(VEC[3], 8, 1'b1);
        send(VEC[5], 8, 1'b0);
        idle(3);
        check(n_pkt == base + 2, "R9 back to back count", 64'(n_pkt - base), 64'h2);
        check_pkt(base, VEC[2], "R9 first");
        check_pkt(base + 1, VEC[3], "R9 second");

        // R1: reset mid-window discards it
        base = n_pkt;
        send(VEC[0], 4, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        send(VEC[0], 4, 1'b0);
        idle(3);
        check(n_pkt == base, "R1 window cut by reset", 64'(n_pkt - base), 64'h0);
        check(row_pkt_o == 0, "R1 outputs cleared by reset", 64'(row_pkt_o), 64'h0);

        check(n_split == 0, "R6 strobes aligned", 64'(n_split), 64'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule